// File: doc/BRIEF.md
# Single-Precision Float to Unsigned Integer Truncating Converter

This block turns an IEEE-754 binary32 value into a 32-bit unsigned integer. The fractional part is always discarded toward zero, and no rounding mode input exists. Two exception bits go with each result for the surrounding flag logic. The invalid bit reports a value that cannot be represented, and the inexact bit reports a fraction that was thrown away. The two bits are mutually exclusive: whenever invalid is raised, inexact is held low.

Each conversion is started by a one-cycle strobe on `in_valid` together with the operand. The result comes out of a two-stage pipeline and is marked by `out_done`. A new operand may be presented on every cycle. The operand layout is the standard one: bit 31 is the sign, bits 30:23 hold the exponent with a bias of 127, and bits 22:0 hold the fraction. Any negative operand except negative zero returns 0 with invalid. Positive values that do not fit saturate to all ones.

Top module: `f2u_trunc_conv`

## Requirements
- R1: An operand captured with `in_valid` high at clock edge k produces `out_done` high during the cycle after edge k+1, with its result on the outputs at that time. `out_done` is low in every cycle that follows no capture.
- R2: An operand with exponent field 255 and a nonzero fraction (a NaN of either sign) returns 0 with invalid set.
- R3: `out_invalid` and `out_inexact` are never both set.
- R4: Any operand with the sign bit set that is not a zero returns 0, sets invalid and leaves inexact clear. This covers negative NaN, negative infinity, negative denormals and negative values of magnitude below 1.
- R5: Positive zero (0x00000000) and negative zero (0x80000000) both return 0 with no exception bit set.
- R6: Positive operands whose value is 2^32 or more (exponent field 159 or above) return 0xFFFFFFFF with invalid set. This includes +infinity (0x7F800000).
- R7: A positive operand with an exponent field from 127 to 158 returns the integer part of its value. Inexact is set exactly when the discarded fraction is nonzero.
- R8: Positive operands with an exponent field below 127 that are not zero return 0 with inexact set. This covers the denormals.
- R9: While reset is high and after it, until the first result, `out_value` is 0 and `out_invalid`, `out_inexact` and `out_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe, one conversion per high cycle |
| in_bits | input | 32 | Binary32 operand: sign 31, exponent 30:23, fraction 22:0 |
| out_value | output | 32 | Unsigned truncated result, held until the next result |
| out_invalid | output | 1 | Invalid exception for the current result |
| out_inexact | output | 1 | Inexact exception for the current result |
| out_done | output | 1 | High for one cycle when a new result is on the outputs |

## Verification
A result is due on the second rising edge after the edge that captures its operand. The bench drives inputs on falling edges. After the capture edge it confirms that `out_done` is still low. One falling edge later it checks the value, both flags and `out_done` against an integer model built from the requirements. A back-to-back run then applies an operand on every cycle and checks, at each falling edge, the result of the operand applied two cycles earlier. The sweep covers every exponent of both signs with fractions at the edges, in the middle and pseudo-random, so each class boundary is hit at its exact latency.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

  // Operand class, decided once in the first pipeline stage
  typedef enum logic [2:0] {
    CLS_ZERO,  // either signed zero
    CLS_NAN,   // any NaN
    CLS_NEG,   // negative, nonzero, not NaN
    CLS_OVER,  // positive, at or above 2^INT_W, or +inf
    CLS_TINY,  // positive, below one (denormals included)
    CLS_NORM   // positive, integer part fits
  } f2u_cls_e;

endpackage

// File: rtl/f2u_classify.sv
module f2u_classify
  import f2u_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int FLT_W = 1 + EXP_W + MAN_W,
  localparam int SH_W  = $clog2(INT_W)
) (
  input  logic [FLT_W-1:0] op_bits,
  output f2u_cls_e         op_cls,
  output logic [SH_W-1:0]  op_shamt,
  output logic [MAN_W:0]   op_sig
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W:0] BIAS_X = (EXP_W + 1)'(BIAS);
  localparam logic [EXP_W:0] OVER_X = (EXP_W + 1)'(BIAS + INT_W);

  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;
  logic [EXP_W:0]   expo_x;
  logic [EXP_W:0]   e_unb;

  assign sgn    = op_bits[FLT_W-1];
  assign expo   = op_bits[FLT_W-2:MAN_W];
  assign frac   = op_bits[MAN_W-1:0];
  assign expo_x = {1'b0, expo};
  assign e_unb  = expo_x - BIAS_X;

  // Precedence: zero, NaN, negative, overflow, below one, normal
  always_comb begin
    if (expo == '0 && frac == '0)       op_cls = CLS_ZERO;
    else if (expo == '1 && frac != '0)  op_cls = CLS_NAN;
    else if (sgn)                       op_cls = CLS_NEG;
    else if (expo_x >= OVER_X)          op_cls = CLS_OVER;
    else if (expo_x < BIAS_X)           op_cls = CLS_TINY;
    else                                op_cls = CLS_NORM;
  end

  assign op_shamt = e_unb[SH_W-1:0];
  assign op_sig   = {1'b1, frac};

endmodule

// File: rtl/f2u_shifter.sv
module f2u_shifter #(
  parameter int SIG_W = 24,
  parameter int SH_W  = 5,
  parameter int OUT_W = 55
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [SH_W-1:0]  shamt,
  output logic [OUT_W-1:0] wide
);

  // Logarithmic left shifter, one stage per shift-amount bit
  logic [OUT_W-1:0] stage [0:SH_W];

  assign stage[0] = OUT_W'(sig);

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    assign stage[g+1] = shamt[g] ? (stage[g] << (1 << g)) : stage[g];
  end

  assign wide = stage[SH_W];

endmodule

// File: rtl/f2u_trunc_conv.sv
module f2u_trunc_conv
  import f2u_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int FLT_W = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [FLT_W-1:0] in_bits,
  output logic [INT_W-1:0] out_value,
  output logic             out_invalid,
  output logic             out_inexact,
  output logic             out_done
);

  localparam int SH_W  = $clog2(INT_W);
  localparam int SIG_W = MAN_W + 1;
  localparam int WIDE_W = INT_W + MAN_W;

  // Stage 0: classification
  f2u_cls_e          c_cls;
  logic [SH_W-1:0]   c_shamt;
  logic [SIG_W-1:0]  c_sig;

  f2u_classify #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)
  ) u_cls (
    .op_bits (in_bits),
    .op_cls  (c_cls),
    .op_shamt(c_shamt),
    .op_sig  (c_sig)
  );

  // Stage 1 registers
  logic              s1_valid;
  f2u_cls_e          s1_cls;
  logic [SH_W-1:0]   s1_shamt;
  logic [SIG_W-1:0]  s1_sig;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_cls   <= CLS_ZERO;
      s1_shamt <= '0;
      s1_sig   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_cls   <= c_cls;
        s1_shamt <= c_shamt;
        s1_sig   <= c_sig;
      end
    end
  end

  // Stage 1: alignment; integer part above MAN_W, dropped fraction below
  logic [WIDE_W-1:0] s1_wide;

  f2u_shifter #(
    .SIG_W(SIG_W), .SH_W(SH_W), .OUT_W(WIDE_W)
  ) u_shf (
    .sig  (s1_sig),
    .shamt(s1_shamt),
    .wide (s1_wide)
  );

  logic [INT_W-1:0] n_value;
  logic             n_invalid;
  logic             n_inexact;

  always_comb begin
    n_value   = '0;
    n_invalid = 1'b0;
    n_inexact = 1'b0;
    unique case (s1_cls)
      CLS_NAN, CLS_NEG: n_invalid = 1'b1;
      CLS_OVER: begin
        n_value   = '1;
        n_invalid = 1'b1;
      end
      CLS_TINY: n_inexact = 1'b1;
      CLS_NORM: begin
        n_value   = s1_wide[WIDE_W-1:MAN_W];
        n_inexact = |s1_wide[MAN_W-1:0];
      end
      default: ;
    endcase
  end

  // Stage 2: output registers, held between results
  always_ff @(posedge clk) begin
    if (rst) begin
      out_value   <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_done    <= 1'b0;
    end else begin
      out_done <= s1_valid;
      if (s1_valid) begin
        out_value   <= n_value;
        out_invalid <= n_invalid;
        out_inexact <= n_inexact;
      end
    end
  end

endmodule

// File: rtl/f2u_trunc_conv_chk.sv
module f2u_trunc_conv_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int FLT_W = 1 + EXP_W + MAN_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [FLT_W-1:0] in_bits,
  input logic [INT_W-1:0] out_value,
  input logic             out_invalid,
  input logic             out_inexact,
  input logic             out_done
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);

  logic             a_sgn;
  logic [EXP_W-1:0] a_exp;
  logic [MAN_W-1:0] a_man;
  logic             a_nan;
  logic             a_zero;

  assign a_sgn  = in_bits[FLT_W-1];
  assign a_exp  = in_bits[FLT_W-2:MAN_W];
  assign a_man  = in_bits[MAN_W-1:0];
  assign a_nan  = (a_exp == '1) && (a_man != '0);
  assign a_zero = (a_exp == '0) && (a_man == '0);

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_done);  // R1

  AST_NAN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_nan) |-> ##2 (out_value == '0 && out_invalid));  // R2

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_invalid && out_inexact));  // R3

  AST_NEG_INVALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_sgn && !a_zero) |-> ##2
      (out_value == '0 && out_invalid && !out_inexact));  // R4

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_zero) |-> ##2
      (out_value == '0 && !out_invalid && !out_inexact));  // R5

  AST_POS_INF_SAT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !a_sgn && a_exp == '1 && a_man == '0) |-> ##2
      (out_value == '1 && out_invalid));  // R6

  AST_UNIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !a_sgn && a_exp == BIAS_E) |-> ##2
      (out_value == INT_W'(1) && out_inexact == (a_man != '0)));  // R7

  AST_BELOW_ONE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !a_sgn && !a_zero && a_exp < BIAS_E) |-> ##2
      (out_value == '0 && out_inexact && !out_invalid));  // R8

endmodule

bind f2u_trunc_conv f2u_trunc_conv_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_bits    (in_bits),
  .out_value  (out_value),
  .out_invalid(out_invalid),
  .out_inexact(out_inexact),
  .out_done   (out_done)
);

// File: tb/f2u_trunc_conv_test.sv
module f2u_trunc_conv_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_bits = '0;
  logic [31:0] out_value;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  f2u_trunc_conv uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_bits    (in_bits),
    .out_value  (out_value),
    .out_invalid(out_invalid),
    .out_inexact(out_inexact),
    .out_done   (out_done)
  );

  // Expected {invalid, inexact, value}, from the requirements
  function automatic logic [33:0] model(input logic [31:0] b);
    logic [7:0]  ex;
    logic [22:0] mn;
    logic [63:0] sig;
    logic [63:0] val;
    logic [63:0] fr;
    int e;
    ex = b[30:23];
    mn = b[22:0];
    if (ex == 8'd0 && mn == '0)        return {2'b00, 32'd0};          // R5
    if (ex == 8'hFF && mn != '0)       return {2'b10, 32'd0};          // R2
    if (b[31])                         return {2'b10, 32'd0};          // R4
    if (ex >= 8'd159)                  return {2'b10, 32'hFFFF_FFFF};  // R6
    if (ex < 8'd127)                   return {2'b01, 32'd0};          // R8
    e   = int'(ex) - 127;                                              // R7
    sig = {40'd0, 1'b1, mn};
    if (e >= 23) begin
      val = sig << (e - 23);
      fr  = '0;
    end else begin
      val = sig >> (23 - e);
      fr  = sig & ((64'd1 << (23 - e)) - 64'd1);
    end
    return {1'b0, fr != '0, val[31:0]};
  endfunction

  function automatic string tag_of(input logic [31:0] b);
    if (b[30:0] == '0)                         return "R5";
    if (b[30:23] == 8'hFF && b[22:0] != '0)    return "R2";
    if (b[31])                                 return "R4";
    if (b[30:23] >= 8'd159)                    return "R6";
    if (b[30:23] < 8'd127)                     return "R8";
    return "R7";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_result(input logic [31:0] b);
    logic [33:0] m;
    string t;
    m = model(b);
    t = tag_of(b);
    check(t, $sformatf("value of %h", b), out_value, m[31:0]);
    check(t, $sformatf("invalid of %h", b), 32'(out_invalid), 32'(m[33]));
    check(t, $sformatf("inexact of %h", b), 32'(out_inexact), 32'(m[32]));
    check("R3", "flags exclusive", 32'(out_invalid & out_inexact), 32'd0);
  endtask

  // One isolated conversion with latency checks (R1)
  task automatic convert(input logic [31:0] b);
    @(negedge clk);
    in_bits  = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "done early", 32'(out_done), 32'd0);
    @(negedge clk);
    check("R1", "done on time", 32'(out_done), 32'd1);
    check_result(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [22:0] rnd;
    logic [31:0] lcg;
    logic [31:0] vec [0:39];

    repeat (4) @(negedge clk);
    // R9: reset state
    check("R9", "reset value", out_value, 32'd0);
    check("R9", "reset invalid", 32'(out_invalid), 32'd0);
    check("R9", "reset inexact", 32'(out_inexact), 32'd0);
    check("R9", "reset done", 32'(out_done), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "idle done after reset", 32'(out_done), 32'd0);

    // Directed boundaries
    convert(32'h0000_0000);  // R5 +0
    convert(32'h8000_0000);  // R5 -0
    convert(32'h3F80_0000);  // R7 1.0
    convert(32'h3FC0_0000);  // R7 1.5 truncates to 1, inexact
    convert(32'h4F00_0000);  // R7 2^31
    convert(32'h4F7F_FFFF);  // R7 largest below 2^32
    convert(32'h4F80_0000);  // R6 2^32
    convert(32'h7F80_0000);  // R6 +inf
    convert(32'hFF80_0000);  // R4 -inf
    convert(32'hBF00_0000);  // R4 -0.5
    convert(32'h8000_0001);  // R4 negative denormal
    convert(32'h0000_0001);  // R8 smallest denormal
    convert(32'h3F7F_FFFF);  // R8 just below one
    convert(32'h7FC0_0000);  // R2 quiet NaN
    convert(32'hFFFF_FFFF);  // R2 negative NaN
    convert(32'h7F80_0001);  // R2 signalling NaN

    // Sweep: every exponent, both signs, selected fractions
    rnd = 23'h1A2B3C;
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 256; e++) begin
        for (int k = 0; k < 6; k++) begin
          logic [22:0] mn;
          rnd = rnd * 23'd1103 + 23'd12345;
          case (k)
            0: mn = 23'h000000;
            1: mn = 23'h000001;
            2: mn = 23'h400000;
            3: mn = 23'h7FFFFF;
            4: mn = 23'h000100;
            default: mn = rnd;
          endcase
          convert({s[0], e[7:0], mn});
        end
      end
    end

    // Back-to-back stream: result of operand i-2 at each falling edge (R1)
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 40; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      vec[i] = {lcg[31], 2'b10, lcg[28:0]} ^ ((i % 3 == 0) ? 32'h0 : 32'h0800_0000);
    end
    for (int i = 0; i < 42; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R1", "stream done", 32'(out_done), 32'd1);
        check_result(vec[i-2]);
      end
      if (i < 40) begin
        in_bits  = vec[i];
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R1", "stream done drops", 32'(out_done), 32'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule